// File: doc/BRIEF.md
# Secure Register Access Filter

This block guards a small register file holding a control override word, a security control word, general configuration words and performance counter words. Every request carries a protection field. Bit 1 of that field gives the requester's security: 0 is Secure and 1 is Non-secure. Secure requests reach every mapped register. Non-secure requests reach only the registers that the current security setting opens to them.

A Non-secure access that is refused finishes quietly, with no error. A refused read returns zero and a refused write is dropped. The security control register can only be written by Secure requests. It can open the configuration registers to Non-secure software, and it can close the counter registers so that only Secure requests reach them. The control override register and the security control register stay Secure-only in every setting.

Each request is a single-cycle valid pulse. One clock later the block raises a ready pulse and returns the read data and an OKAY response. Addresses are byte addresses of 32-bit words.

Top module: `sec_reg_filter`

## Requirements
- R1: A request with `req_prot_i[1]` = 0 is Secure and can read and write every mapped register: 0x00 override (32 bits), 0x04 security control, 0x08 and 0x0C configuration (32 bits each), and 0x10, 0x14, 0x18, 0x1C counters (32 bits each). Bits 0 and 2 of `req_prot_i` have no effect.
- R2: After reset every register reads as zero. With the security control at its reset value, Non-secure requests can access only the four counter registers.
- R3: A Non-secure read of a register it is not allowed to access returns all-zero data.
- R4: A Non-secure write to a register it is not allowed to access leaves that register unchanged.
- R5: Every request, whether allowed or not, is answered exactly one clock later by a single-cycle `rsp_ready_o` pulse with `rsp_resp_o` = 2'b00 (OKAY). No error code is ever returned, and `rsp_ready_o` stays low when there is no request.
- R6: When bit 0 of the security control register is 1, Non-secure requests can read and write the configuration registers at 0x08 and 0x0C.
- R7: The override register (0x00) and the security control register (0x04) refuse Non-secure requests whatever the security control value is.
- R8: When bit 1 of the security control register is 1, Non-secure requests to the counter registers are refused. When that bit is 0, Non-secure requests can access the counters.
- R9: Reads from an unmapped address (0x20 and above) or from an address whose bits [1:0] are not 00 return zero, and writes to such addresses are ignored, for both Secure and Non-secure requests.
- R10: A write to the security control register governs the very next request, including a request that arrives in the following cycle.
- R11: The security control register keeps only write-data bits [1:0]. Its bits [31:2] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 8 | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_prot_i | input | 3 | Protection field; bit 1 set means Non-secure |
| rsp_ready_o | output | 1 | Response pulse, one clock after the request |
| rsp_rdata_o | output | 32 | Read data, zero for refused or unmapped reads |
| rsp_resp_o | output | 2 | Response code, always OKAY (00) |

## Verification
The bench sweeps all four security control settings. In each setting it visits every word address, plus two unmapped addresses and a misaligned one. At each address it makes a Secure write, then a Non-secure write of the complementary value, then reads back both as Secure and as Non-secure. The Secure read-back shows whether the Non-secure write landed, and the Non-secure read shows whether data leaks out or is zeroed. Together these separate the three register groups from the unmapped space. The bench varies the protection bits other than bit 1, to show that they are ignored. Back-to-back requests right after a change of security control show that the new setting takes effect on the next cycle.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;
  typedef enum logic [1:0] {
    RGN_CTRL = 2'd0,
    RGN_CFG  = 2'd1,
    RGN_CNT  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  typedef struct packed {
    logic cnt_sec_only;
    logic ns_open;
  } sec_ctl_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/sec_filter_decide.sv
module sec_filter_decide
  import sec_filter_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int N_CFG = 2,
  parameter int N_CNT = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             aligned_i,
  input  logic             ns_i,
  input  sec_ctl_t         ctl_i,
  output region_e          region_o,
  output logic             allowed_o
);
  localparam int CFG_BASE = 2;
  localparam int CNT_BASE = CFG_BASE + N_CFG;
  localparam int END_IDX  = CNT_BASE + N_CNT;
  localparam logic [IDX_W-1:0] CFG_LO = IDX_W'(CFG_BASE);
  localparam logic [IDX_W-1:0] CNT_LO = IDX_W'(CNT_BASE);
  localparam logic [IDX_W-1:0] END_LO = IDX_W'(END_IDX);

  always_comb begin
    if (!aligned_i || idx_i >= END_LO) region_o = RGN_NONE;
    else if (idx_i >= CNT_LO)          region_o = RGN_CNT;
    else if (idx_i >= CFG_LO)          region_o = RGN_CFG;
    else                               region_o = RGN_CTRL;
  end

  always_comb begin
    unique case (region_o)
      RGN_CTRL: allowed_o = !ns_i;
      RGN_CFG:  allowed_o = !ns_i || ctl_i.ns_open;
      RGN_CNT:  allowed_o = !ns_i || !ctl_i.cnt_sec_only;
      default:  allowed_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sec_filter_regs.sv
module sec_filter_regs
  import sec_filter_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  parameter int N_CFG  = 2,
  parameter int N_CNT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_val_o,
  output sec_ctl_t          ctl_o
);
  localparam int CFG_BASE = 2;
  localparam int CNT_BASE = CFG_BASE + N_CFG;
  localparam logic [IDX_W-1:0] OVR_IDX = IDX_W'(0);
  localparam logic [IDX_W-1:0] CTL_IDX = IDX_W'(1);

  logic [DATA_W-1:0] ovr_q;
  sec_ctl_t          ctl_q;
  logic [DATA_W-1:0] cfg_q [N_CFG];
  logic [DATA_W-1:0] cnt_q [N_CNT];
  logic [N_CFG-1:0]  cfg_we;
  logic [N_CNT-1:0]  cnt_we;

  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg_we
    assign cfg_we[g] = wr_en_i && (idx_i == IDX_W'(CFG_BASE + g));
  end
  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt_we
    assign cnt_we[g] = wr_en_i && (idx_i == IDX_W'(CNT_BASE + g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= '0;
      ctl_q <= '0;
      for (int i = 0; i < N_CFG; i++) cfg_q[i] <= '0;
      for (int i = 0; i < N_CNT; i++) cnt_q[i] <= '0;
    end else begin
      if (wr_en_i && idx_i == OVR_IDX) ovr_q <= wdata_i;
      if (wr_en_i && idx_i == CTL_IDX) ctl_q <= sec_ctl_t'(wdata_i[1:0]);
      for (int i = 0; i < N_CFG; i++) if (cfg_we[i]) cfg_q[i] <= wdata_i;
      for (int i = 0; i < N_CNT; i++) if (cnt_we[i]) cnt_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rd_val_o = '0;
    if (idx_i == OVR_IDX) rd_val_o = ovr_q;
    if (idx_i == CTL_IDX) rd_val_o = {{(DATA_W-2){1'b0}}, ctl_q};
    for (int i = 0; i < N_CFG; i++)
      if (idx_i == IDX_W'(CFG_BASE + i)) rd_val_o = cfg_q[i];
    for (int i = 0; i < N_CNT; i++)
      if (idx_i == IDX_W'(CNT_BASE + i)) rd_val_o = cnt_q[i];
  end

  assign ctl_o = ctl_q;

  AST_CTL_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctl_q) |-> $past(wr_en_i && idx_i == CTL_IDX)); // R10
endmodule

// File: rtl/sec_reg_filter.sv
module sec_reg_filter
  import sec_filter_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_CFG  = 2,
  parameter int N_CNT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [2:0]        req_prot_i,
  output logic              rsp_ready_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [1:0]        rsp_resp_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              req_ns;
  logic              unused_prot_bits;
  region_e           region;
  logic              allowed;
  sec_ctl_t          ctl;
  logic [DATA_W-1:0] rd_val;
  logic              ready_q;
  logic [DATA_W-1:0] rdata_q;

  assign idx              = req_addr_i[ADDR_W-1:2];
  assign aligned          = (req_addr_i[1:0] == 2'b00);
  assign req_ns           = req_prot_i[1];
  assign unused_prot_bits = req_prot_i[0] ^ req_prot_i[2];

  sec_filter_decide #(.IDX_W(IDX_W), .N_CFG(N_CFG), .N_CNT(N_CNT)) u_decide (
    .idx_i    (idx),
    .aligned_i(aligned),
    .ns_i     (req_ns),
    .ctl_i    (ctl),
    .region_o (region),
    .allowed_o(allowed)
  );

  sec_filter_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W), .N_CFG(N_CFG), .N_CNT(N_CNT)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (req_valid_i && req_write_i && allowed),
    .idx_i   (idx),
    .wdata_i (req_wdata_i),
    .rd_val_o(rd_val),
    .ctl_o   (ctl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= req_valid_i;
      rdata_q <= (req_valid_i && !req_write_i && allowed) ? rd_val : '0;
    end
  end

  assign rsp_ready_o = ready_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_resp_o  = RESP_OKAY;

  AST_READY_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_ready_o); // R5
  AST_NO_SPURIOUS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_ready_o); // R5
  AST_NS_CTRL_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_ns && region == RGN_CTRL) |=> rsp_rdata_o == '0); // R3
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && region == RGN_NONE) |=> rsp_rdata_o == '0); // R9
  AST_NS_CTL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_ns && idx == IDX_W'(1)) |=> $stable(ctl)); // R7
  AST_NS_OVR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_ns && aligned && idx == IDX_W'(0)) |=> $stable(u_regs.ovr_q)); // R4
endmodule

// File: tb/tb_sec_reg_filter.sv
`timescale 1ns/1ps
module tb_sec_reg_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  prot = '0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_resp;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sec_reg_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_prot_i(prot),
    .rsp_ready_o(rsp_ready), .rsp_rdata_o(rsp_rdata), .rsp_resp_o(rsp_resp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected Non-secure permission for word index given control bits {cnt_sec_only, ns_open}
  function automatic bit ns_ok(input int idx, input logic [1:0] ctl);
    if (idx == 2 || idx == 3) return ctl[0];
    if (idx >= 4 && idx <= 7) return !ctl[1];
    return 1'b0;
  endfunction

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [2:0] p, output logic [31:0] rd);
    @(negedge clk);
    valid = 1'b1; write = w; addr = a; wdata = d; prot = p;
    @(negedge clk);
    valid = 1'b0;
    rd = rsp_rdata;
    chk(rsp_ready === 1'b1 && rsp_resp === 2'b00, "R5", {30'd0, rsp_resp}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] ps, pn, exp_s, exp_n;
    logic [2:0]  sp, np;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_ready === 1'b0, "R5", {31'd0, rsp_ready}, 32'd0);
    // R2: reset values
    for (int i = 0; i < 8; i++) begin
      acc(1'b0, 8'(i*4), '0, 3'b000, rd);
      chk(rd === 32'd0, "R2", rd, 32'd0);
    end
    // R2: reset control lets Non-secure reach counters only
    acc(1'b1, 8'h10, 32'h1234_5678, 3'b010, rd);
    acc(1'b0, 8'h10, '0, 3'b010, rd);
    chk(rd === 32'h1234_5678, "R2", rd, 32'h1234_5678);
    acc(1'b1, 8'h08, 32'hDEAD_BEEF, 3'b010, rd);
    acc(1'b0, 8'h08, '0, 3'b000, rd);
    chk(rd === 32'd0, "R2", rd, 32'd0);

    // sweep every control setting, every word, both securities
    for (int c = 0; c < 4; c++) begin
      acc(1'b1, 8'h04, 32'hFFFF_FFFC | 32'(c), 3'b000, rd);
      acc(1'b0, 8'h04, '0, 3'b100, rd);
      chk(rd === 32'(c), "R11", rd, 32'(c));
      for (int i = 0; i < 11; i++) begin
        logic [7:0] a;
        bit mapped;
        if (i == 1) continue;
        a = (i == 10) ? 8'h09 : 8'(i*4);
        if (i == 9) a = 8'hFC;
        mapped = (i < 8);
        sp = (i % 2) ? 3'b101 : 3'b000;
        np = (i % 2) ? 3'b010 : 3'b111;
        ps = 32'hA500_0000 | (32'(c) << 8) | 32'(i);
        pn = ~ps;
        acc(1'b1, a, ps, sp, rd);
        acc(1'b1, a, pn, np, rd);
        exp_s = !mapped ? 32'd0 : (ns_ok(i, 2'(c)) ? pn : ps);
        acc(1'b0, a, '0, sp, rd);
        chk(rd === exp_s, mapped ? (ns_ok(i, 2'(c)) ? "R6/R8 write" : "R4") : "R9",
            rd, exp_s);
        exp_n = (mapped && ns_ok(i, 2'(c))) ? exp_s : 32'd0;
        acc(1'b0, a, '0, np, rd);
        chk(rd === exp_n, mapped ? (ns_ok(i, 2'(c)) ? "R1 R6 R8" : "R3") : "R9", rd, exp_n);
        if (i == 0) chk(exp_s === ps, "R7", exp_s, ps);
      end
      // R7: control register refuses Non-secure in every setting
      acc(1'b1, 8'h04, 32'(c ^ 3), 3'b010, rd);
      acc(1'b0, 8'h04, '0, 3'b000, rd);
      chk(rd === 32'(c), "R7", rd, 32'(c));
      acc(1'b0, 8'h04, '0, 3'b010, rd);
      chk(rd === 32'd0, "R7", rd, 32'd0);
    end

    // R10: back-to-back, control change governs the following request
    acc(1'b1, 8'h04, 32'd0, 3'b000, rd);
    acc(1'b1, 8'h0C, 32'h0BAD_F00D, 3'b000, rd);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = 8'h04; wdata = 32'd1; prot = 3'b000;
    @(negedge clk);
    write = 1'b0; addr = 8'h0C; wdata = '0; prot = 3'b010;
    @(negedge clk);
    valid = 1'b0;
    chk(rsp_ready === 1'b1 && rsp_rdata === 32'h0BAD_F00D, "R10", rsp_rdata, 32'h0BAD_F00D);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = 8'h04; wdata = 32'd2; prot = 3'b000;
    @(negedge clk);
    write = 1'b0; addr = 8'h14; wdata = '0; prot = 3'b010;
    @(negedge clk);
    valid = 1'b0;
    chk(rsp_ready === 1'b1 && rsp_rdata === 32'd0, "R10", rsp_rdata, 32'd0);
    @(negedge clk);
    chk(rsp_ready === 1'b0, "R5", {31'd0, rsp_ready}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule